// File: doc/BRIEF.md
# I2C Controller Status Flags

This block holds the status flags of an I2C controller and presents them to the rest of the chip as one 16-bit read-only status word. The bit-level bus engine reports bus events to it as single-cycle strobes: Start, Repeated Start, Stop, address match, general call match, second byte of a matching 10-bit address, a completed received byte, the start of a master transmission, the end of an acknowledge slot with the sampled level, and a bus collision. The software side reports a write to the transmit buffer, a read of the receive buffer, and per-bit clear strobes.

Each flag has its own rule. Some flags follow bus events only, some are sticky until software clears them, and some track buffer occupancy. The block derives a busy condition from its own flags to decide whether a transmit buffer write is accepted or rejected as a write collision.

Top module: `i2c_status_flags`

## Requirements
- R1: After reset every bit of `statusWord` is 0. Bits 13, 12, 11 and 2 always read 0.
- R2: On `evAckDone`, bit 15 takes the value of `ackLevel` (1 = NACK, 0 = ACK), visible the cycle after the strobe.
- R3: Bit 14 (transmit in progress) sets on `evMstTxBegin` and clears on `evAckDone`.
- R4: Bit 10 (bus collision) sets on `evCollision` and clears only when `swClr[10]` is pulsed.
- R5: Bit 9 (general call) sets on `evGenCall`. Bit 8 (10-bit match) sets on `ev10bitSecond`. Both clear on `evStop`.
- R6: A `swTxWrite` while busy, meaning bit 0 or bit 14 is set, sets bit 7 (write collision) and leaves bit 0 unchanged. Bit 7 clears only on `swClr[7]`.
- R7: Bit 0 (transmit buffer full) sets on a `swTxWrite` that is accepted while not busy, and clears on `evTxLoad`.
- R8: Bit 1 (receive buffer full) sets on `evByteRcvd` and clears on `swRxRead`. When `evByteRcvd` arrives while bit 1 is set and no `swRxRead` occurs in the same cycle, bit 6 (receive overflow) sets. Bit 6 clears only on `swClr[6]`.
- R9: Bit 5 (data/address) clears on `evAddrMatch` and sets on `evByteRcvd` with `byteIsData` high.
- R10: Bit 4 (Stop seen) sets on `evStop` and clears on `evStart` or `evRestart`. Bit 3 (Start seen) sets on `evStart` or `evRestart` and clears on `evStop`.
- R11: `swClr` bits other than 10, 7 and 6 have no effect on any flag.
- R12: When a set event and a clear event reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evStart | input | 1 | Start condition detected |
| evRestart | input | 1 | Repeated Start detected |
| evStop | input | 1 | Stop condition detected |
| evAddrMatch | input | 1 | Own device address matched |
| evGenCall | input | 1 | General call address received |
| ev10bitSecond | input | 1 | Second byte of matching 10-bit address received |
| evByteRcvd | input | 1 | Received byte ready for the receive buffer |
| byteIsData | input | 1 | Qualifies evByteRcvd as a slave data byte |
| evMstTxBegin | input | 1 | Master transmission of a byte begins |
| evAckDone | input | 1 | End of an acknowledge slot |
| ackLevel | input | 1 | Sampled acknowledge level, 1 = NACK |
| evCollision | input | 1 | Bus collision during a master operation |
| evTxLoad | input | 1 | Transmit buffer byte moved into the shifter |
| swTxWrite | input | 1 | Software write to the transmit buffer |
| swRxRead | input | 1 | Software read of the receive buffer |
| swClr | input | 16 | Per-bit software clear strobes |
| statusWord | output | 16 | Status word |

## Verification
On every cycle the assertions check that the acknowledge bit follows the sampled level, that transmit-in-progress rises after a transmit begins, that the collision flags stay set until their own clear strobe, that a rejected write leaves the buffer-full bit alone, that the Stop and Start bits follow a lone Stop, and that any set command leaves its flag high. The bench scenarios cover the rest. Random event mixes show the general call and 10-bit flags clearing on Stop, overflow arising only from a second unread byte, data/address toggling, and non-clearable bits ignoring their `swClr` strobes.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int WordW = 16;

  localparam int BitAck   = 15;
  localparam int BitTxing = 14;
  localparam int BitColl  = 10;
  localparam int BitGc    = 9;
  localparam int BitTen   = 8;
  localparam int BitWcol  = 7;
  localparam int BitOvf   = 6;
  localparam int BitData  = 5;
  localparam int BitStop  = 4;
  localparam int BitStart = 3;
  localparam int BitRxFul = 1;
  localparam int BitTxFul = 0;

  // Bits that hold a flag; all others read 0
  localparam logic [WordW-1:0] ImplMask = 16'b1100_0111_1111_1011;
  // Bits that software may clear
  localparam logic [WordW-1:0] SwClrMask = 16'b0000_0100_1100_0000;

  typedef struct packed {
    logic [WordW-1:0] setV;
    logic [WordW-1:0] clrV;
  } flagCmd_t;
endpackage

// File: rtl/i2c_stat_ctrl.sv
module i2c_stat_ctrl
  import i2c_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             evStart,
  input  logic             evRestart,
  input  logic             evStop,
  input  logic             evAddrMatch,
  input  logic             evGenCall,
  input  logic             ev10bitSecond,
  input  logic             evByteRcvd,
  input  logic             byteIsData,
  input  logic             evMstTxBegin,
  input  logic             evAckDone,
  input  logic             ackLevel,
  input  logic             evCollision,
  input  logic             evTxLoad,
  input  logic             swTxWrite,
  input  logic             swRxRead,
  input  logic [WordW-1:0] swClr,
  input  logic [WordW-1:0] curFlags,
  output flagCmd_t         cmd
);
  logic busy;
  logic anyStart;
  logic [WordW-1:0] swClrEff;

  assign busy     = curFlags[BitTxFul] | curFlags[BitTxing];
  assign anyStart = evStart | evRestart;
  assign swClrEff = swClr & SwClrMask;

  always_comb begin
    cmd = '0;
    // acknowledge status loads the sampled level
    cmd.setV[BitAck]   = evAckDone & ackLevel;
    cmd.clrV[BitAck]   = evAckDone & ~ackLevel;
    // transmit in progress
    cmd.setV[BitTxing] = evMstTxBegin;
    cmd.clrV[BitTxing] = evAckDone;
    // bus collision, sticky
    cmd.setV[BitColl]  = evCollision;
    cmd.clrV[BitColl]  = swClrEff[BitColl];
    // general call and 10-bit match, cleared by Stop
    cmd.setV[BitGc]    = evGenCall;
    cmd.clrV[BitGc]    = evStop;
    cmd.setV[BitTen]   = ev10bitSecond;
    cmd.clrV[BitTen]   = evStop;
    // write collision, sticky
    cmd.setV[BitWcol]  = swTxWrite & busy;
    cmd.clrV[BitWcol]  = swClrEff[BitWcol];
    // receive overflow, sticky
    cmd.setV[BitOvf]   = evByteRcvd & curFlags[BitRxFul] & ~swRxRead;
    cmd.clrV[BitOvf]   = swClrEff[BitOvf];
    // data / address
    cmd.setV[BitData]  = evByteRcvd & byteIsData;
    cmd.clrV[BitData]  = evAddrMatch;
    // Stop / Start seen
    cmd.setV[BitStop]  = evStop;
    cmd.clrV[BitStop]  = anyStart;
    cmd.setV[BitStart] = anyStart;
    cmd.clrV[BitStart] = evStop;
    // buffer occupancy
    cmd.setV[BitRxFul] = evByteRcvd;
    cmd.clrV[BitRxFul] = swRxRead;
    cmd.setV[BitTxFul] = swTxWrite & ~busy;
    cmd.clrV[BitTxFul] = evTxLoad;
  end

  // R6: a busy write yields a write collision and is discarded
  p_wcol_discard_r6: assert property (@(posedge clk) disable iff (!rstN)
    (swTxWrite && busy && !evTxLoad) |=> (curFlags[BitWcol] && curFlags[BitTxFul] == $past(curFlags[BitTxFul])));

  // R4: collision flag holds until its own clear strobe
  p_coll_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (curFlags[BitColl] && !swClr[BitColl]) |=> curFlags[BitColl]);

  // R8: overflow holds until its own clear strobe
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (curFlags[BitOvf] && !swClr[BitOvf]) |=> curFlags[BitOvf]);
endmodule

// File: rtl/i2c_stat_regs.sv
module i2c_stat_regs
  import i2c_stat_pkg::*;
#(
  parameter logic [WordW-1:0] Impl = ImplMask
) (
  input  logic             clk,
  input  logic             rstN,
  input  flagCmd_t         cmd,
  output logic [WordW-1:0] flags
);
  for (genvar i = 0; i < WordW; i++) begin : g_bit
    if (Impl[i]) begin : g_flop
      logic q;
      always_ff @(posedge clk) begin
        if (!rstN)              q <= 1'b0;
        else if (cmd.setV[i])   q <= 1'b1;   // set wins
        else if (cmd.clrV[i])   q <= 1'b0;
      end
      assign flags[i] = q;

      // R12: a set command always leaves the flag high
      p_set_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
        cmd.setV[i] |=> flags[i]);
      // a lone clear command leaves the flag low
      p_clr_only_r12: assert property (@(posedge clk) disable iff (!rstN)
        (cmd.clrV[i] && !cmd.setV[i]) |=> !flags[i]);
    end else begin : g_zero
      assign flags[i] = 1'b0;
    end
  end
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
  import i2c_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evStart,
  input  logic              evRestart,
  input  logic              evStop,
  input  logic              evAddrMatch,
  input  logic              evGenCall,
  input  logic              ev10bitSecond,
  input  logic              evByteRcvd,
  input  logic              byteIsData,
  input  logic              evMstTxBegin,
  input  logic              evAckDone,
  input  logic              ackLevel,
  input  logic              evCollision,
  input  logic              evTxLoad,
  input  logic              swTxWrite,
  input  logic              swRxRead,
  input  logic [WordW-1:0]  swClr,
  output logic [WordW-1:0]  statusWord
);
  flagCmd_t cmd;
  logic [WordW-1:0] flags;

  i2c_stat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .evStart(evStart), .evRestart(evRestart), .evStop(evStop),
    .evAddrMatch(evAddrMatch), .evGenCall(evGenCall), .ev10bitSecond(ev10bitSecond),
    .evByteRcvd(evByteRcvd), .byteIsData(byteIsData),
    .evMstTxBegin(evMstTxBegin), .evAckDone(evAckDone), .ackLevel(ackLevel),
    .evCollision(evCollision), .evTxLoad(evTxLoad),
    .swTxWrite(swTxWrite), .swRxRead(swRxRead), .swClr(swClr),
    .curFlags(flags), .cmd(cmd)
  );

  i2c_stat_regs #(.Impl(ImplMask)) u_regs (
    .clk(clk), .rstN(rstN), .cmd(cmd), .flags(flags)
  );

  assign statusWord = flags;

  // R2: acknowledge bit follows the sampled level
  p_ack_level_r2: assert property (@(posedge clk) disable iff (!rstN)
    evAckDone |=> (statusWord[BitAck] == $past(ackLevel)));

  // R3: transmit in progress rises after a transmit begins
  p_txing_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    evMstTxBegin |=> statusWord[BitTxing]);

  // R10: a lone Stop shows Stop seen and clears Start seen
  p_stop_seen_r10: assert property (@(posedge clk) disable iff (!rstN)
    (evStop && !evStart && !evRestart) |=> (statusWord[BitStop] && !statusWord[BitStart]));

  // R1: unused bits stay low
  p_unused_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[13:11] == 3'b000) && !statusWord[2]);
endmodule

// File: tb/test_i2c_status_flags.sv
module test_i2c_status_flags;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evStart = 0, evRestart = 0, evStop = 0, evAddrMatch = 0, evGenCall = 0;
  logic ev10bitSecond = 0, evByteRcvd = 0, byteIsData = 0, evMstTxBegin = 0;
  logic evAckDone = 0, ackLevel = 0, evCollision = 0, evTxLoad = 0;
  logic swTxWrite = 0, swRxRead = 0;
  logic [15:0] swClr = '0;
  logic [15:0] statusWord;

  int nChecks = 0;
  int nFails = 0;
  logic [15:0] expWord = '0;

  always #10 clk = ~clk;  // 50 MHz

  i2c_status_flags i_i2c_status_flags (
    .clk(clk), .rstN(rstN),
    .evStart(evStart), .evRestart(evRestart), .evStop(evStop),
    .evAddrMatch(evAddrMatch), .evGenCall(evGenCall), .ev10bitSecond(ev10bitSecond),
    .evByteRcvd(evByteRcvd), .byteIsData(byteIsData),
    .evMstTxBegin(evMstTxBegin), .evAckDone(evAckDone), .ackLevel(ackLevel),
    .evCollision(evCollision), .evTxLoad(evTxLoad),
    .swTxWrite(swTxWrite), .swRxRead(swRxRead), .swClr(swClr),
    .statusWord(statusWord)
  );

  // requirement owning each status bit
  function automatic string bitReq(int b);
    case (b)
      15: return "R2";  14: return "R3";  10: return "R4";
      9, 8: return "R5"; 7: return "R6";  6: return "R8";
      5: return "R9";   4, 3: return "R10"; 1: return "R8";
      0: return "R7";   default: return "R1";
    endcase
  endfunction

  // next expected word from the requirements
  function automatic logic [15:0] nextWord(logic [15:0] s);
    logic [15:0] n = s;
    logic busy = s[0] | s[14];
    logic st = evStart | evRestart;
    if (evAckDone) n[15] = ackLevel;
    if (evAckDone) n[14] = 1'b0;
    if (evMstTxBegin) n[14] = 1'b1;
    if (swClr[10]) n[10] = 1'b0;
    if (evCollision) n[10] = 1'b1;
    if (evStop) begin n[9] = 1'b0; n[8] = 1'b0; end
    if (evGenCall) n[9] = 1'b1;
    if (ev10bitSecond) n[8] = 1'b1;
    if (swClr[7]) n[7] = 1'b0;
    if (swTxWrite && busy) n[7] = 1'b1;
    if (swClr[6]) n[6] = 1'b0;
    if (evByteRcvd && s[1] && !swRxRead) n[6] = 1'b1;
    if (evAddrMatch) n[5] = 1'b0;
    if (evByteRcvd && byteIsData) n[5] = 1'b1;
    if (st) n[4] = 1'b0;
    if (evStop) n[4] = 1'b1;
    if (evStop) n[3] = 1'b0;
    if (st) n[3] = 1'b1;
    if (swRxRead) n[1] = 1'b0;
    if (evByteRcvd) n[1] = 1'b1;
    if (evTxLoad) n[0] = 1'b0;
    if (swTxWrite && !busy) n[0] = 1'b1;
    return n;
  endfunction

  task automatic check(string tag);
    nChecks++;
    if (statusWord !== expWord) begin
      nFails++;
      if (tag == "") begin
        for (int b = 15; b >= 0; b--)
          if (statusWord[b] !== expWord[b]) begin tag = bitReq(b); break; end
      end
      $display("FAIL %s: status actual %h expected %h", tag, statusWord, expWord);
    end
  endtask

  task automatic idle();
    {evStart, evRestart, evStop, evAddrMatch, evGenCall, ev10bitSecond} = '0;
    {evByteRcvd, byteIsData, evMstTxBegin, evAckDone, ackLevel} = '0;
    {evCollision, evTxLoad, swTxWrite, swRxRead} = '0;
    swClr = '0;
  endtask

  // apply current inputs for one edge, then check at the following low phase
  task automatic step(string tag);
    expWord = nextWord(expWord);
    @(negedge clk);
    check(tag);
    idle();
  endtask

  initial begin
    int unused = $urandom(32'h1C5A7);
    idle();
    repeat (3) @(negedge clk);
    expWord = '0;
    check("R1");
    rstN = 1'b1;

    // R7 accepted write then R6 collision while full
    swTxWrite = 1; step("R7");
    swTxWrite = 1; step("R6");
    evTxLoad = 1; step("R7");
    // R3 / R2 transmit and NACK
    evMstTxBegin = 1; step("R3");
    evAckDone = 1; ackLevel = 1; step("R2");
    evAckDone = 1; ackLevel = 0; step("R2");
    // R8 overflow on second unread byte
    evByteRcvd = 1; step("R8");
    evByteRcvd = 1; step("R8");
    swRxRead = 1; evByteRcvd = 1; step("R8");
    // R11 non-clearable bits ignore swClr
    swClr = 16'hFFFF & ~16'h04C0; step("R11");
    // R4 sticky collision and R12 set wins over clear
    evCollision = 1; step("R4");
    evCollision = 1; swClr[10] = 1; step("R12");
    swClr = 16'h04C0; step("R4");
    // R5 and R10 general call, 10-bit, Stop
    evGenCall = 1; ev10bitSecond = 1; evStart = 1; step("R5");
    evStop = 1; step("R10");
    evRestart = 1; step("R10");
    // R9 data/address
    evAddrMatch = 1; step("R9");
    evByteRcvd = 1; byteIsData = 1; step("R9");

    // constrained random mix
    for (int c = 0; c < 3000; c++) begin
      evStart       = ($urandom_range(15) == 0);
      evRestart     = ($urandom_range(31) == 0);
      evStop        = ($urandom_range(15) == 0);
      evAddrMatch   = ($urandom_range(7) == 0);
      evGenCall     = ($urandom_range(15) == 0);
      ev10bitSecond = ($urandom_range(15) == 0);
      evByteRcvd    = ($urandom_range(5) == 0);
      byteIsData    = $urandom_range(1);
      evMstTxBegin  = ($urandom_range(7) == 0);
      evAckDone     = ($urandom_range(7) == 0);
      ackLevel      = $urandom_range(1);
      evCollision   = ($urandom_range(31) == 0);
      evTxLoad      = ($urandom_range(5) == 0);
      swTxWrite     = ($urandom_range(5) == 0);
      swRxRead      = ($urandom_range(5) == 0);
      swClr         = ($urandom_range(7) == 0) ? 16'($urandom) : 16'h0;
      step("");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule